// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits between the receive side of an Ethernet MAC and a byte-wide packet memory. Frames arrive as a byte stream with valid and last markers. Once the six destination bytes have arrived, the block decides whether to keep the frame. The decision uses the station address, the promiscuous, broadcast and multicast enables, a stop flag, and the amount of free room in the ring.

An accepted frame is stored in a circular buffer made of 256-byte pages that lies between a start page and a stop page. The frame begins in the page named by the current-page pointer. Its first four bytes are a header that holds a status byte, the page where the next frame will start, and the stored length. After the header is written, the current-page pointer moves on and a one-cycle received pulse is raised.

The block writes the payload as it streams in and writes the header at the end. It holds the destination bytes back and stores them during a short tail phase after the last input byte. Padding and the header are also written in that tail phase. The input is not ready during the tail phase.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame is accepted when any one of these holds: `cfg_promisc` is 1; all six destination bytes are 0xFF and `cfg_bcast_en` is 1; bit 0 of the first destination byte is 1 and `cfg_mcast_en` is 1; the destination equals `station_addr`. The first byte received is compared with `station_addr[47:40]`. Any other frame is dropped and causes no memory write.
- R2: No frame is accepted while `cfg_stop` is 1 at the moment the sixth byte arrives.
- R3: Free room is counted in bytes. When the current page is below the boundary page, it is (boundary − current)·256. Otherwise it is (stop − start)·256 − (current − boundary)·256. A frame is dropped when the free room is below 1518.
- R4: An accepted frame shorter than 60 bytes is extended with zero bytes to 60 bytes. The stored length counts the padding.
- R5: The next page is current + ⌊(L + 8 + 255)/256⌋, where L is the padded length. If the result is at or above the stop page, (stop − start) is subtracted from it.
- R6: The header occupies bytes 0..3 of the frame's first page. Byte 0 is the status, byte 1 is the next page, byte 2 is the low byte of L+4 and byte 3 is the high byte of L+4.
- R7: Bit 0 of the status byte is always 1. Bit 5 of the status byte is 1 exactly when bit 0 of the first destination byte is 1. All other status bits are 0.
- R8: Frame byte i goes to address page·256 + 4 + i. When the address reaches stop·256 during a frame, it continues at start·256.
- R9: After the last header byte is written, `cur_page` takes the next-page value and `rx_done` is high for exactly one cycle. After reset, `cur_page` is 0 and `rx_done` is 0.
- R10: `in_ready` is 1 from the first byte to the last byte of every frame, including dropped frames. It is 0 from the cycle after the last byte of an accepted frame until the header is written. It is 1 after reset.
- R11: A frame whose last byte arrives before its sixth byte is dropped.
- R12: `cur_load` overwrites `cur_page` with `cur_load_page`. Memory writes appear on `mem_we`, `mem_addr` and `mem_wdata` one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block can take a byte |
| cfg_stop | input | 1 | Refuse all frames |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_bcast_en | input | 1 | Accept the all-ones destination |
| cfg_mcast_en | input | 1 | Accept group destinations |
| station_addr | input | 48 | Own address, first byte in bits 47:40 |
| ring_start | input | 8 | First page of the ring |
| ring_stop | input | 8 | Page just past the ring |
| boundary_page | input | 8 | Oldest page not yet consumed |
| cur_load | input | 1 | Load the current-page pointer |
| cur_load_page | input | 8 | Value for `cur_load` |
| cur_page | output | 8 | Page where the next frame starts |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| rx_done | output | 1 | One-cycle frame-stored pulse |

## Verification
The hardest case to reach is a frame that crosses the stop page. Reaching it needs the current page sitting on the last page of the ring, a boundary placed so that the room check still passes, and a frame long enough to spill past the page end. The bench gets there by loading the pointer directly and moving the boundary first. The room threshold is checked from both sides, with one setting that leaves 1280 bytes free and one that leaves 1536. Every write is compared in order against a behavioural model, so the deferred destination bytes and the header written last are both checked against their exact addresses.

// File: rtl/rxw_pkg.sv
// Shared constants and types for the receive ring writer.
package rxw_pkg;
    typedef enum logic [1:0] {
        ST_RECV,   // taking frame bytes
        ST_PAD,    // writing zero padding
        ST_DEST,   // writing held destination bytes
        ST_HDR     // writing the 4-byte header
    } rxw_state_e;

    localparam int HDR_BYTES  = 4;
    localparam int CRC_BYTES  = 4;
    localparam int ST_OK_BIT  = 0;
    localparam int ST_GRP_BIT = 5;
endpackage

// File: rtl/rxw_addr_filter.sv
// Destination filter. It is purely combinational.
// Assumes dest holds the first received byte in its top eight bits.
module rxw_addr_filter #(
    parameter int MAC_BYTES = 6
) (
    input  logic [MAC_BYTES*8-1:0] dest,
    input  logic [MAC_BYTES*8-1:0] station,
    input  logic                   promisc,
    input  logic                   bcast_en,
    input  logic                   mcast_en,
    output logic                   pass,
    output logic                   group
);
    localparam int MAC_W = MAC_BYTES * 8;

    logic is_bcast;
    logic is_own;

    // Classify the destination and combine it with the enables.
    always_comb begin
        is_bcast = &dest;
        is_own   = (dest == station);
        group    = dest[MAC_W-8];
        pass     = promisc | (is_bcast & bcast_en) | (group & mcast_en) | is_own;
    end
endmodule

// File: rtl/rxw_space_check.sv
// Ring free-room check. It reports whether a maximum-size frame still fits.
// Assumes start < stop and that both the current and boundary pages lie inside the ring.
module rxw_space_check #(
    parameter int PAGE_W = 8,
    parameter int THRESH = 1518
) (
    input  logic [PAGE_W-1:0] cur,
    input  logic [PAGE_W-1:0] bnd,
    input  logic [PAGE_W-1:0] start,
    input  logic [PAGE_W-1:0] stop,
    output logic              room_ok
);
    localparam int DW = PAGE_W + 2;
    localparam int BW = PAGE_W + 10;
    localparam logic signed [BW-1:0] THR = BW'(THRESH);

    logic signed [DW-1:0] pdiff;
    logic signed [BW-1:0] free_b;

    // Count free pages, then scale them to bytes.
    always_comb begin
        if (cur < bnd)
            pdiff = $signed({2'b00, bnd}) - $signed({2'b00, cur});
        else
            pdiff = ($signed({2'b00, stop}) - $signed({2'b00, start}))
                  - ($signed({2'b00, cur}) - $signed({2'b00, bnd}));
        free_b  = $signed({pdiff, 8'h00});
        room_ok = (free_b >= THR);
    end
endmodule

// File: rtl/rxw_next_page.sv
// Next-frame page calculation with wrap at the stop page.
// Assumes len is the padded frame length and start < stop.
module rxw_next_page #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [LEN_W-1:0]  len,
    input  logic [PAGE_W-1:0] start,
    input  logic [PAGE_W-1:0] stop,
    output logic [PAGE_W-1:0] nxt
);
    import rxw_pkg::*;
    localparam int SW = LEN_W + 2;

    logic [SW-1:0] pages;
    logic [SW-1:0] sum;

    // Round the stored size up to whole pages, then wrap.
    always_comb begin
        pages = (SW'(len) + SW'(HDR_BYTES + CRC_BYTES + 255)) >> 8;
        sum   = SW'(page) + pages;
        if (sum >= SW'(stop))
            sum = sum - SW'(stop - start);
        nxt = sum[PAGE_W-1:0];
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring writer. It filters frames and stores the accepted ones in a paged ring.
// Frame bytes 6 and up are written as they arrive. Padding, the held destination bytes
// and the header are written in a tail phase, during which in_ready is low.
// Assumes the host does not load cur_page while a frame is in progress.
module rx_ring_writer #(
    parameter int PAGE_W    = 8,
    parameter int LEN_W     = 16,
    parameter int MAC_BYTES = 6,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    input  logic                   in_last,
    output logic                   in_ready,
    input  logic                   cfg_stop,
    input  logic                   cfg_promisc,
    input  logic                   cfg_bcast_en,
    input  logic                   cfg_mcast_en,
    input  logic [MAC_BYTES*8-1:0] station_addr,
    input  logic [PAGE_W-1:0]      ring_start,
    input  logic [PAGE_W-1:0]      ring_stop,
    input  logic [PAGE_W-1:0]      boundary_page,
    input  logic                   cur_load,
    input  logic [PAGE_W-1:0]      cur_load_page,
    output logic [PAGE_W-1:0]      cur_page,
    output logic                   mem_we,
    output logic [PAGE_W+7:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    output logic                   rx_done
);
    import rxw_pkg::*;

    localparam int ADDR_W = PAGE_W + 8;
    localparam int MAC_W  = MAC_BYTES * 8;
    localparam int THRESH = MAX_FRAME + CRC_BYTES;
    localparam int STEP_W = $clog2(MAC_BYTES + 1);

    rxw_state_e          state;
    logic [LEN_W-1:0]    cnt;
    logic [7:0]          dbuf [MAC_BYTES];
    logic                acc_q;
    logic                grp_q;
    logic [PAGE_W-1:0]   fpage;
    logic [ADDR_W-1:0]   daddr;
    logic [STEP_W-1:0]   step;

    logic                hs;
    logic                decide_now;
    logic                acc_now;
    logic [MAC_W-1:0]    dest_vec;
    logic                flt_pass;
    logic                flt_grp;
    logic                room_ok;
    logic [PAGE_W-1:0]   nxt_page;
    logic [ADDR_W-1:0]   page_base;
    logic [7:0]          dest_byte;
    logic [7:0]          hdr_byte;
    logic [15:0]         total_len;
    logic [7:0]          status_b;

    // Destination vector: held bytes plus the byte arriving now.
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_dest
        if (g == MAC_BYTES - 1) begin : g_live
            assign dest_vec[MAC_W-1-8*g -: 8] = in_data;
        end else begin : g_held
            assign dest_vec[MAC_W-1-8*g -: 8] = dbuf[g];
        end
    end

    rxw_addr_filter #(.MAC_BYTES(MAC_BYTES)) u_filter (
        .dest     (dest_vec),
        .station  (station_addr),
        .promisc  (cfg_promisc),
        .bcast_en (cfg_bcast_en),
        .mcast_en (cfg_mcast_en),
        .pass     (flt_pass),
        .group    (flt_grp)
    );

    rxw_space_check #(.PAGE_W(PAGE_W), .THRESH(THRESH)) u_space (
        .cur     (fpage),
        .bnd     (boundary_page),
        .start   (ring_start),
        .stop    (ring_stop),
        .room_ok (room_ok)
    );

    rxw_next_page #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
        .page  (fpage),
        .len   (cnt),
        .start (ring_start),
        .stop  (ring_stop),
        .nxt   (nxt_page)
    );

    // Step a ring address by one byte, going back to the start page at the stop page.
    function automatic logic [ADDR_W-1:0] ring_adv(input logic [ADDR_W-1:0] a,
                                                   input logic [PAGE_W-1:0] st,
                                                   input logic [PAGE_W-1:0] sp);
        logic [ADDR_W:0] n;
        n = {1'b0, a} + 1'b1;
        if (n == {1'b0, sp, 8'h00})
            return {st, 8'h00};
        return n[ADDR_W-1:0];
    endfunction

    // Handshake and accept decision.
    always_comb begin
        in_ready   = (state == ST_RECV);
        hs         = in_valid & in_ready;
        decide_now = hs && (cnt == LEN_W'(MAC_BYTES - 1));
        acc_now    = decide_now ? (flt_pass & room_ok & ~cfg_stop) : acc_q;
    end

    // Tail data: the held destination byte and the header byte for the current step.
    always_comb begin
        page_base = {fpage, 8'h00};
        total_len = 16'(cnt) + 16'(HDR_BYTES);
        status_b  = 8'(1 << ST_OK_BIT) | (grp_q ? 8'(1 << ST_GRP_BIT) : 8'h00);
        dest_byte = 8'h00;
        for (int k = 0; k < MAC_BYTES; k++)
            if (step == STEP_W'(k)) dest_byte = dbuf[k];
        case (step)
            STEP_W'(0): hdr_byte = status_b;
            STEP_W'(1): hdr_byte = nxt_page;
            STEP_W'(2): hdr_byte = total_len[7:0];
            default:    hdr_byte = total_len[15:8];
        endcase
    end

    // Main sequencer: frame intake, padding, destination write-back, header, pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RECV;
            cnt       <= '0;
            acc_q     <= 1'b0;
            grp_q     <= 1'b0;
            fpage     <= '0;
            daddr     <= '0;
            step      <= '0;
            cur_page  <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rx_done   <= 1'b0;
            for (int k = 0; k < MAC_BYTES; k++) dbuf[k] <= '0;
        end else begin
            mem_we  <= 1'b0;
            rx_done <= 1'b0;
            if (cur_load)
                cur_page <= cur_load_page;
            case (state)
                ST_RECV: begin
                    if (hs) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == '0) begin
                            fpage <= cur_page;
                            daddr <= {cur_page, 8'h00} + ADDR_W'(HDR_BYTES + MAC_BYTES);
                        end
                        for (int k = 0; k < MAC_BYTES; k++)
                            if (cnt == LEN_W'(k)) dbuf[k] <= in_data;
                        if (decide_now) begin
                            acc_q <= acc_now;
                            grp_q <= flt_grp;
                        end
                        if (cnt >= LEN_W'(MAC_BYTES) && acc_q) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= daddr;
                            mem_wdata <= in_data;
                            daddr     <= ring_adv(daddr, ring_start, ring_stop);
                        end
                        if (in_last) begin
                            step <= '0;
                            if (cnt < LEN_W'(MAC_BYTES - 1) || !acc_now) begin
                                cnt   <= '0;
                                acc_q <= 1'b0;
                            end else if ((cnt + 1'b1) < LEN_W'(MIN_FRAME)) begin
                                state <= ST_PAD;
                            end else begin
                                state <= ST_DEST;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= daddr;
                    mem_wdata <= 8'h00;
                    daddr     <= ring_adv(daddr, ring_start, ring_stop);
                    cnt       <= cnt + 1'b1;
                    if (cnt == LEN_W'(MIN_FRAME - 1))
                        state <= ST_DEST;
                end
                ST_DEST: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= page_base + ADDR_W'(HDR_BYTES) + ADDR_W'(step);
                    mem_wdata <= dest_byte;
                    if (step == STEP_W'(MAC_BYTES - 1)) begin
                        step  <= '0;
                        state <= ST_HDR;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= page_base + ADDR_W'(step);
                    mem_wdata <= hdr_byte;
                    if (step == STEP_W'(HDR_BYTES - 1)) begin
                        cur_page <= nxt_page;
                        rx_done  <= 1'b1;
                        state    <= ST_RECV;
                        cnt      <= '0;
                        acc_q    <= 1'b0;
                        step     <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);  // R9
    AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (cur_page >= ring_start && cur_page < ring_stop));  // R5
    AST_STOP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && cfg_stop) |=> !acc_q);  // R2
    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {ring_start, 8'h00} && mem_addr < {ring_stop, 8'h00}));  // R8
    AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && in_last && acc_now && cnt >= LEN_W'(MAC_BYTES - 1)) |=> !in_ready);  // R10
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        cfg_stop = 1'b0, cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0;
    logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
    logic [7:0]  ring_start = 8'h40, ring_stop = 8'h60, boundary_page = 8'h40;
    logic        cur_load = 1'b0;
    logic [7:0]  cur_load_page = 8'h00;
    logic [7:0]  cur_page;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        rx_done;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .cfg_stop(cfg_stop), .cfg_promisc(cfg_promisc),
        .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_en(cfg_mcast_en), .station_addr(station_addr),
        .ring_start(ring_start), .ring_stop(ring_stop), .boundary_page(boundary_page),
        .cur_load(cur_load), .cur_load_page(cur_load_page), .cur_page(cur_page),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_done(rx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          nchk = 0, nerr = 0, cyc = 0, done_cnt = 0, exp_done = 0;
    bit          finished = 1'b0;
    string       tag = "R9";
    logic [23:0] exp_q[$];
    logic [7:0]  frm[$];
    int          mcur = 0;

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Compare every memory write against the model's queue and count done pulses.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) chk({tag, " unexpected write"}, {8'h00, mem_addr, mem_wdata}, 32'hFFFFFFFF);
            else chk(tag, {8'h00, mem_addr, mem_wdata}, {8'h00, exp_q.pop_front()});
        end
        if (rst_n && rx_done) done_cnt++;
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic load_cur(int p);
        @(negedge clk); cur_load = 1'b1; cur_load_page = 8'(p);
        @(negedge clk); cur_load = 1'b0;
        mcur = p;
    endtask

    task automatic mk(logic [47:0] d, int len, int seed);
        frm.delete();
        for (int k = 0; k < 6 && k < len; k++) frm.push_back(d[47-8*k -: 8]);
        for (int i = 6; i < len; i++) frm.push_back(8'(seed + i * 7 + 1));
    endtask

    // Behavioural model: decides on the frame and queues the writes it expects.
    function automatic bit model();
        int len, plen, a, nxt, total, free_b, base, start, stop;
        bit own, bc, grp, ok;
        len = frm.size(); start = ring_start; stop = ring_stop;
        if (len < 6) return 1'b0;
        own = 1'b1; bc = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (frm[k] != station_addr[47-8*k -: 8]) own = 1'b0;
            if (frm[k] != 8'hFF) bc = 1'b0;
        end
        grp = frm[0][0];
        ok = cfg_promisc || (bc && cfg_bcast_en) || (grp && cfg_mcast_en) || own;
        if (mcur < boundary_page) free_b = (boundary_page - mcur) * 256;
        else free_b = (stop - start) * 256 - (mcur - boundary_page) * 256;
        if (!ok || cfg_stop || free_b < 1518) return 1'b0;
        plen = (len < 60) ? 60 : len;
        base = mcur * 256;
        a = base + 10;
        for (int i = 6; i < plen; i++) begin
            exp_q.push_back({16'(a), (i < len) ? frm[i] : 8'h00});
            a++;
            if (a == stop * 256) a = start * 256;
        end
        for (int k = 0; k < 6; k++) exp_q.push_back({16'(base + 4 + k), frm[k]});
        total = plen + 4;
        nxt = mcur + (plen + 8 + 255) / 256;
        if (nxt >= stop) nxt = nxt - (stop - start);
        exp_q.push_back({16'(base), grp ? 8'h21 : 8'h01});
        exp_q.push_back({16'(base + 1), 8'(nxt)});
        exp_q.push_back({16'(base + 2), 8'(total)});
        exp_q.push_back({16'(base + 3), 8'(total >> 8)});
        mcur = nxt;
        exp_done++;
        return 1'b1;
    endfunction

    // Drive one frame a byte per cycle, then let the tail finish and check the results.
    task automatic send(string t);
        bit acc, stall;
        tag = t;
        while (!in_ready) @(negedge clk);
        acc = model();
        stall = 1'b0;
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = frm[i]; in_last = (i == frm.size() - 1);
            #1;
            if (!in_ready) stall = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk({t, " R10 ready during frame"}, {31'b0, stall}, 32'd0);
        if (acc) chk({t, " R10 ready low in tail"}, {31'b0, in_ready}, 32'd0);
        repeat (90) @(negedge clk);
        chk({t, " pending writes"}, exp_q.size(), 32'd0);
        exp_q.delete();
        chk({t, " R9 cur_page"}, {24'b0, cur_page}, 32'(mcur));
        chk({t, " R9 done count"}, done_cnt, exp_done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", {31'b0, in_ready}, 32'd1);
        chk("R9 reset done", {31'b0, rx_done}, 32'd0);
        chk("R9 reset cur", {24'b0, cur_page}, 32'd0);
        chk("R12 reset we", {31'b0, mem_we}, 32'd0);

        load_cur(8'h40);
        chk("R12 cur load", {24'b0, cur_page}, 32'h40);

        mk(48'h0A1B2C3D4E5F, 64, 3);   send("R1 R6 R7 R8 own 64");
        mk(48'h0A1B2C3D4E5F, 20, 9);   send("R4 pad 20");
        mk(48'h0A1B2C3D4E5F, 60, 5);   send("R4 exact 60");
        cfg_bcast_en = 1'b1;
        mk(48'hFFFFFFFFFFFF, 70, 11);  send("R1 R7 bcast on");
        cfg_bcast_en = 1'b0;
        mk(48'hFFFFFFFFFFFF, 70, 11);  send("R1 bcast off");
        cfg_mcast_en = 1'b1;
        mk(48'h01005E000001, 80, 13);  send("R1 R7 mcast on");
        cfg_mcast_en = 1'b0;
        mk(48'h01005E000001, 80, 13);  send("R1 mcast off");
        cfg_promisc = 1'b1;
        mk(48'h001122334455, 65, 17);  send("R1 promisc on");
        cfg_promisc = 1'b0;
        mk(48'h001122334455, 65, 17);  send("R1 mismatch");
        cfg_stop = 1'b1;
        mk(48'h0A1B2C3D4E5F, 64, 19);  send("R2 stopped");
        cfg_stop = 1'b0;
        mk(48'h0A1B2C3D4E5F, 5, 21);   send("R11 runt 5");
        mk(48'h0A1B2C3D4E5F, 6, 23);   send("R11 R4 six bytes");

        boundary_page = 8'h50;
        load_cur(8'h5F);
        mk(48'h0A1B2C3D4E5F, 300, 29); send("R8 R5 wrap");

        load_cur(8'h41);
        boundary_page = 8'h46;
        mk(48'h0A1B2C3D4E5F, 100, 31); send("R3 room 1280");
        boundary_page = 8'h47;
        mk(48'h0A1B2C3D4E5F, 100, 31); send("R3 room 1536");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule